// File: doc/BRIEF.md
# Processor exception entry controller

This block sits beside a 32-bit core's pipeline and handles the moment an exception is accepted. When the core raises a general exception, it gives the faulting program counter, a cause code and, if it has one, the faulting virtual address. The block then saves that state into the exception registers and reports which handler vector the fetch unit must use. The choice rests on the current processor status. A core already inside a handler is sent to the double-fault vector. Otherwise the user-mode bit picks the user vector or the kernel vector.

A debug request carries its own cause. It is accepted only when the core's current interrupt level is strictly below the configured debug level. An accepted debug request saves the program counter and the previous status word into the registers kept for that level. It then raises the status interrupt level to the debug level. The core may also load the status word directly, which is how mode changes and handler exits reach the block. Every update for one event commits on a single clock edge, and the vector code is shown for exactly the cycle after that edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, every saved-state output is zero: status level, user bit and handler bit, EPC1, DEPC, the cause registers, the faulting address, and the debug-level EPC and EPS. `vec_o` shows 0 (none).
- R2: A general exception taken while the handler bit is 0 and the user bit is 0 writes the faulting PC into EPC1 and shows `vec_o` = 1 (kernel).
- R3: A general exception taken while the handler bit is 0 and the user bit is 1 writes the faulting PC into EPC1 and shows `vec_o` = 2 (user).
- R4: A general exception taken while the handler bit is 1 shows `vec_o` = 3 (double). With HAS_DEPC=1 the PC goes into DEPC and EPC1 is unchanged. With HAS_DEPC=0 the PC goes into EPC1 and DEPC is unchanged.
- R5: Every general exception writes its cause code into the exception cause register and leaves the handler bit set. The user bit and the status level are unchanged.
- R6: The faulting-address register is loaded from `exc_vaddr_i` only when `exc_addr_vld_i` is 1 with the request. Otherwise it keeps its value.
- R7: A debug request is taken only when `cur_level_i` < DBG_LEVEL. Otherwise it is ignored: no register changes and `vec_o` stays 0.
- R8: A taken debug request has these effects:
  - it writes the debug cause register and the debug-level EPC with the PC;
  - it writes the debug-level EPS with the previous status word, packed as bits [5:2] level, [1] user bit, [0] handler bit;
  - it sets the status level to DBG_LEVEL and the handler bit to 1, and keeps the user bit;
  - it shows `vec_o` = 4 (debug).
- R9: When a taken debug request and a general exception arrive in the same cycle, only the debug request commits. The exception cause register, EPC1 and DEPC are untouched.
- R10: `vec_o` is nonzero only in the cycle right after a request commits. A direct status load leaves it at 0.
- R11: `ps_load_i` writes `ps_wdata_i` into the status word (same packing as R8) only in a cycle with no committing request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 1 | General exception request |
| exc_pc_i | input | XLEN | Faulting PC for either request |
| exc_cause_i | input | CAUSE_W | General exception cause |
| exc_addr_vld_i | input | 1 | Request carries a faulting address |
| exc_vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug request |
| dbg_cause_i | input | CAUSE_W | Debug cause |
| cur_level_i | input | LVL_W | Current interrupt level of the core |
| ps_load_i | input | 1 | Direct status-word load |
| ps_wdata_i | input | 6 | Status word to load |
| vec_o | output | 3 | Vector code: 0 none, 1 kernel, 2 user, 3 double, 4 debug |
| ps_level_o | output | LVL_W | Status interrupt level |
| ps_um_o | output | 1 | Status user bit |
| ps_excm_o | output | 1 | Status handler bit |
| epc1_o | output | XLEN | First-level saved PC |
| depc_o | output | XLEN | Double-fault saved PC |
| exc_cause_o | output | CAUSE_W | Exception cause register |
| exc_vaddr_o | output | XLEN | Faulting address register |
| dbg_cause_o | output | CAUSE_W | Debug cause register |
| epc_dbg_o | output | XLEN | Saved PC at the debug level |
| eps_dbg_o | output | 6 | Saved status word at the debug level |

## Verification
The bench sweeps every combination of user bit, handler bit and address-valid flag. A design that read the user bit while already in a handler would send nested faults to the user or kernel vector and overwrite EPC1. A design that ignored the address-valid flag would corrupt the faulting address. A second instance without DEPC catches a design that routes the double-fault PC by the wrong option. The debug sweep runs every current level from 0 to 15 and finds an off-by-one gate, because that gate would accept or refuse the request at level DBG_LEVEL itself. A simultaneous debug and general request shows a design that lets both commit, since it would overwrite the exception cause.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_KERNEL = 3'd1,
    VEC_USER   = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } vec_e;

  localparam int LVL_W = 4;
  localparam int PS_W  = LVL_W + 2;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic             um;
    logic             excm;
  } ps_t;

endpackage

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate #(
  parameter int DBG_LEVEL = 4,
  parameter int LVL_W     = 4
) (
  input  logic             dbg_req,
  input  logic [LVL_W-1:0] cur_level,
  output logic             dbg_take
);
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  // strict comparison: at the debug level itself the request is masked
  always_comb dbg_take = dbg_req && (cur_level < DBG_LVL_V);
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic exc_req,
  input  logic dbg_take,
  input  ps_t  ps_cur,
  output vec_e vec_next,
  output logic gen_commit,
  output logic wr_epc1,
  output logic wr_depc
);
  always_comb begin
    vec_next   = VEC_NONE;
    gen_commit = 1'b0;
    wr_epc1    = 1'b0;
    wr_depc    = 1'b0;
    if (dbg_take) begin
      vec_next = VEC_DEBUG;
    end else if (exc_req) begin
      gen_commit = 1'b1;
      if (ps_cur.excm) begin
        vec_next = VEC_DOUBLE;
        if (HAS_DEPC) wr_depc = 1'b1;
        else          wr_epc1 = 1'b1;
      end else begin
        vec_next = ps_cur.um ? VEC_USER : VEC_KERNEL;
        wr_epc1  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int XLEN      = 32,
  parameter int PS_W      = 6,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [XLEN-1:0]  wr_pc,
  input  logic [PS_W-1:0]  wr_ps,
  output logic [XLEN-1:0]  rd_pc,
  output logic [PS_W-1:0]  rd_ps
);
  // level 1 lives in the general path; this bank covers levels 2..DBG_LEVEL
  localparam int FIRST = 2;
  localparam int LAST  = DBG_LEVEL;

  logic [XLEN-1:0] epc_q [FIRST:LAST];
  logic [PS_W-1:0] eps_q [FIRST:LAST];

  always_ff @(posedge clk) begin
    for (int l = FIRST; l <= LAST; l++) begin
      if (rst) begin
        epc_q[l] <= '0;
        eps_q[l] <= '0;
      end else if (wr_en && wr_lvl == LVL_W'(l)) begin
        epc_q[l] <= wr_pc;
        eps_q[l] <= wr_ps;
      end
    end
  end

  assign rd_pc = epc_q[LAST];
  assign rd_ps = eps_q[LAST];
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               exc_addr_vld_i,
  input  logic [XLEN-1:0]    exc_vaddr_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic [3:0]         cur_level_i,
  input  logic               ps_load_i,
  input  logic [5:0]         ps_wdata_i,
  output logic [2:0]         vec_o,
  output logic [3:0]         ps_level_o,
  output logic               ps_um_o,
  output logic               ps_excm_o,
  output logic [XLEN-1:0]    epc1_o,
  output logic [XLEN-1:0]    depc_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [XLEN-1:0]    exc_vaddr_o,
  output logic [CAUSE_W-1:0] dbg_cause_o,
  output logic [XLEN-1:0]    epc_dbg_o,
  output logic [5:0]         eps_dbg_o
);
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  ps_t               ps_q;
  vec_e              vec_q;
  logic [XLEN-1:0]   epc1_q, depc_q, vaddr_q;
  logic [CAUSE_W-1:0] cause_q, dcause_q;

  logic dbg_take, gen_commit, wr_epc1, wr_depc;
  vec_e vec_next;

  exc_dbg_gate #(.DBG_LEVEL(DBG_LEVEL), .LVL_W(LVL_W)) u_gate (
    .dbg_req   (dbg_req_i),
    .cur_level (cur_level_i),
    .dbg_take  (dbg_take)
  );

  exc_vec_sel #(.HAS_DEPC(HAS_DEPC)) u_sel (
    .exc_req    (exc_req_i),
    .dbg_take   (dbg_take),
    .ps_cur     (ps_q),
    .vec_next   (vec_next),
    .gen_commit (gen_commit),
    .wr_epc1    (wr_epc1),
    .wr_depc    (wr_depc)
  );

  exc_save_regs #(
    .XLEN(XLEN), .PS_W(PS_W), .LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (dbg_take),
    .wr_lvl (DBG_LVL_V),
    .wr_pc  (exc_pc_i),
    .wr_ps  (ps_q),
    .rd_pc  (epc_dbg_o),
    .rd_ps  (eps_dbg_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q     <= '0;
      vec_q    <= VEC_NONE;
      epc1_q   <= '0;
      depc_q   <= '0;
      vaddr_q  <= '0;
      cause_q  <= '0;
      dcause_q <= '0;
    end else begin
      vec_q <= vec_next;
      if (dbg_take) begin
        dcause_q    <= dbg_cause_i;
        ps_q.level  <= DBG_LVL_V;
        ps_q.excm   <= 1'b1;
      end else if (gen_commit) begin
        cause_q   <= exc_cause_i;
        ps_q.excm <= 1'b1;
        if (exc_addr_vld_i) vaddr_q <= exc_vaddr_i;
        if (wr_epc1)        epc1_q  <= exc_pc_i;
        if (wr_depc)        depc_q  <= exc_pc_i;
      end else if (ps_load_i) begin
        ps_q <= ps_t'(ps_wdata_i);
      end
    end
  end

  assign vec_o       = vec_q;
  assign ps_level_o  = ps_q.level;
  assign ps_um_o     = ps_q.um;
  assign ps_excm_o   = ps_q.excm;
  assign epc1_o      = epc1_q;
  assign depc_o      = depc_q;
  assign exc_cause_o = cause_q;
  assign exc_vaddr_o = vaddr_q;
  assign dbg_cause_o = dcause_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBG_LEVEL = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               exc_req_i,
  input logic [XLEN-1:0]    exc_pc_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic               dbg_req_i,
  input logic [3:0]         cur_level_i,
  input logic               ps_load_i,
  input logic [2:0]         vec_o,
  input logic [3:0]         ps_level_o,
  input logic               ps_um_o,
  input logic               ps_excm_o,
  input logic [CAUSE_W-1:0] exc_cause_o,
  input logic [XLEN-1:0]    epc_dbg_o
);
  logic dbg_ok;
  assign dbg_ok = dbg_req_i && (cur_level_i < 4'(DBG_LEVEL));

  // R10: a vector code only follows a request
  a_r10_vec_after_req: assert property (@(posedge clk) disable iff (rst)
    (vec_o != 3'd0) |-> $past(exc_req_i || dbg_req_i));

  // R4: nested exception goes to the double vector
  a_r4_double_vec: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && !dbg_ok && ps_excm_o) |=> (vec_o == 3'd3));

  // R3: user mode outside a handler selects the user vector
  a_r3_user_vec: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && !dbg_ok && !ps_excm_o && ps_um_o) |=> (vec_o == 3'd2));

  // R5: cause captured and handler bit set
  a_r5_cause_excm: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && !dbg_ok) |=> (ps_excm_o && exc_cause_o == $past(exc_cause_i)));

  // R7: masked debug request with nothing else pending changes nothing
  a_r7_dbg_masked: assert property (@(posedge clk) disable iff (rst)
    (dbg_req_i && !dbg_ok && !exc_req_i && !ps_load_i) |=>
      ($stable(ps_level_o) && $stable(ps_excm_o) && vec_o == 3'd0));

  // R8: taken debug request raises level and saves the PC
  a_r8_dbg_entry: assert property (@(posedge clk) disable iff (rst)
    dbg_ok |=> (ps_level_o == 4'(DBG_LEVEL) && ps_excm_o &&
                vec_o == 3'd4 && epc_dbg_o == $past(exc_pc_i)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DBG_LEVEL(DBG_LEVEL)
) u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  localparam int DBG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 0, addr_vld = 0, dbg_req = 0, ps_load = 0;
  logic [31:0] pc = 0, vaddr = 0;
  logic [5:0]  cause = 0, dcause = 0, ps_wdata = 0;
  logic [3:0]  cur_lvl = 0;

  logic [2:0]  vec0, vec1;
  logic [3:0]  lvl0, lvl1;
  logic        um0, um1, excm0, excm1;
  logic [31:0] epc1_0, epc1_1, depc0, depc1, va0, va1, edbg0, edbg1;
  logic [5:0]  ca0, ca1, dc0, dc1, eps0, eps1;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b1)) u0 (
    .clk(clk), .rst(rst), .exc_req_i(exc_req), .exc_pc_i(pc), .exc_cause_i(cause),
    .exc_addr_vld_i(addr_vld), .exc_vaddr_i(vaddr), .dbg_req_i(dbg_req),
    .dbg_cause_i(dcause), .cur_level_i(cur_lvl), .ps_load_i(ps_load),
    .ps_wdata_i(ps_wdata), .vec_o(vec0), .ps_level_o(lvl0), .ps_um_o(um0),
    .ps_excm_o(excm0), .epc1_o(epc1_0), .depc_o(depc0), .exc_cause_o(ca0),
    .exc_vaddr_o(va0), .dbg_cause_o(dc0), .epc_dbg_o(edbg0), .eps_dbg_o(eps0));

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b0)) u1 (
    .clk(clk), .rst(rst), .exc_req_i(exc_req), .exc_pc_i(pc), .exc_cause_i(cause),
    .exc_addr_vld_i(addr_vld), .exc_vaddr_i(vaddr), .dbg_req_i(dbg_req),
    .dbg_cause_i(dcause), .cur_level_i(cur_lvl), .ps_load_i(ps_load),
    .ps_wdata_i(ps_wdata), .vec_o(vec1), .ps_level_o(lvl1), .ps_um_o(um1),
    .ps_excm_o(excm1), .epc1_o(epc1_1), .depc_o(depc1), .exc_cause_o(ca1),
    .exc_vaddr_o(va1), .dbg_cause_o(dc1), .epc_dbg_o(edbg1), .eps_dbg_o(eps1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // load PS directly; vector must stay at none afterwards
  task automatic set_ps(input logic [3:0] l, input logic u, input logic e);
    @(negedge clk);
    ps_load = 1; ps_wdata = {l, u, e};
    @(negedge clk);
    ps_load = 0;
  endtask

  // one-cycle request; returns the vector seen just after the commit edge
  task automatic pulse(output logic [2:0] v0, output logic [2:0] v1);
    @(posedge clk); #1;
    v0 = vec0; v1 = vec1;
    @(negedge clk);
    exc_req = 0; dbg_req = 0; addr_vld = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0]  v0, v1;
    logic [31:0] m_epc1_0, m_epc1_1, m_depc0, m_depc1, m_va;
    logic [5:0]  m_dc, m_ps;
    logic [31:0] m_edbg;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check("R1 ps", {26'd0, lvl0, um0, excm0}, 32'd0);
    check("R1 epc1", epc1_0, 0);
    check("R1 depc", depc0, 0);
    check("R1 cause", {26'd0, ca0}, 0);
    check("R1 vaddr", va0, 0);
    check("R1 dbg", {edbg0[31:6], edbg0[5:0] | eps0 | dc0}, 0);
    check("R1 vec", {29'd0, vec0}, 0);

    m_epc1_0 = 0; m_epc1_1 = 0; m_depc0 = 0; m_depc1 = 0; m_va = 0;

    // sweep user bit, handler bit, address-valid flag
    for (int g = 0; g < 8; g++) begin
      logic u, e, av;
      logic [2:0] exp_v;
      u = g[0]; e = g[1]; av = g[2];
      set_ps(4'd3, u, e);
      @(posedge clk); #1;
      check("R11 ps_load", {26'd0, lvl0, um0, excm0}, {26'd0, 4'd3, u, e});
      check("R10 no vec on load", {29'd0, vec0}, 0);
      @(negedge clk);
      exc_req = 1; pc = 32'h1000_0000 + 32'(g) * 16; cause = 6'(g + 5);
      addr_vld = av; vaddr = 32'hA000_0000 | 32'(g);
      pulse(v0, v1);
      exp_v = e ? 3'd3 : (u ? 3'd2 : 3'd1);
      if (e) begin
        m_depc0 = 32'h1000_0000 + 32'(g) * 16;
        m_epc1_1 = m_depc0;
      end else begin
        m_epc1_0 = 32'h1000_0000 + 32'(g) * 16;
        m_epc1_1 = m_epc1_0;
      end
      if (av) m_va = 32'hA000_0000 | 32'(g);
      check(e ? "R4 vec" : (u ? "R3 vec" : "R2 vec"), {29'd0, v0}, {29'd0, exp_v});
      check("R4 vec nodepc", {29'd0, v1}, {29'd0, exp_v});
      check("R2 R3 R4 epc1", epc1_0, m_epc1_0);
      check("R4 depc", depc0, m_depc0);
      check("R4 epc1 nodepc", epc1_1, m_epc1_1);
      check("R4 depc nodepc", depc1, m_depc1);
      check("R5 cause", {26'd0, ca0}, 32'(g + 5));
      check("R5 ps", {26'd0, lvl0, um0, excm0}, {26'd0, 4'd3, u, 1'b1});
      check("R6 vaddr", va0, m_va);
      @(posedge clk); #1;
      check("R10 vec one cycle", {29'd0, vec0}, 0);
    end

    // debug gate sweep over every current level
    m_dc = 0; m_edbg = 0; m_ps = 0;
    for (int lv = 0; lv < 16; lv++) begin
      logic take;
      take = (lv < DBG);
      set_ps(4'(lv % 3), lv[0], 1'b0);
      m_ps = {4'(lv % 3), lv[0], 1'b0};
      @(negedge clk);
      dbg_req = 1; cur_lvl = 4'(lv); dcause = 6'(lv + 1);
      pc = 32'hD000_0000 + 32'(lv);
      pulse(v0, v1);
      if (take) begin
        m_dc = 6'(lv + 1); m_edbg = 32'hD000_0000 + 32'(lv);
        check("R8 vec", {29'd0, v0}, 4);
        check("R8 eps", {26'd0, eps0}, {26'd0, m_ps});
        check("R8 ps", {26'd0, lvl0, um0, excm0}, {26'd0, 4'(DBG), lv[0], 1'b1});
      end else begin
        check("R7 vec ignored", {29'd0, v0}, 0);
        check("R7 ps ignored", {26'd0, lvl0, um0, excm0}, {26'd0, m_ps});
      end
      check("R7 R8 dcause", {26'd0, dc0}, {26'd0, m_dc});
      check("R7 R8 epc_dbg", edbg0, m_edbg);
    end

    // simultaneous debug and general request: debug only
    set_ps(4'd1, 1'b0, 1'b0);
    @(negedge clk);
    exc_req = 1; dbg_req = 1; cur_lvl = 0; cause = 6'h3F; dcause = 6'h2A;
    pc = 32'hBEEF_0000; addr_vld = 1; vaddr = 32'h5555_5555;
    pulse(v0, v1);
    check("R9 vec", {29'd0, v0}, 4);
    check("R9 cause kept", {26'd0, ca0}, 32'(7 + 5));
    check("R9 epc1 kept", epc1_0, m_epc1_0);
    check("R9 depc kept", depc0, m_depc0);
    check("R9 vaddr kept", va0, m_va);
    check("R9 dcause", {26'd0, dc0}, 32'h2A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule